// File: doc/BRIEF.md
# Bit-Serial Fraction Scaler

This block scales a two's complement operand that arrives one bit per clock, least significant bit first, by four fixed fractions: 3/8, 7/8, 11/16 and 7/16. It has no multiplier. Each fraction becomes a small integer multiple built from delayed copies of the stream: 3x = x + 2x, 7x = 8x - x, and 11x = 8x + 3x, where 3x is shared with the 3/8 path. Each multiple is formed by a serial adder or subtractor that keeps its carry in a flip-flop. The fraction itself is taken by dropping the lowest three or four bits of the multiple, which is a difference in timing only. The 7/16 result is the 7/8 product with one more bit dropped. The exact product is formed before any bit is discarded, so every result equals the floor of the true product.

A word strobe marks the least significant bit of each operand. A small controller moves through three states. `IDLE` is the state after reset. `BITS` covers the W operand bits. `EXTEND` repeats the captured sign bit after the last operand bit, so shifted copies of a negative operand stay correct. Its transitions are: any state goes to `BITS` on the strobe, `BITS` goes to `EXTEND` on operand bit W-1, and `IDLE` and `EXTEND` hold until the next strobe. Each result has its own native latency: three bits for 3/8 and 7/8, four bits for 11/16 and 7/16. Equalising flops bring all four results to one output strobe. That strobe rises five cycles after the input strobe.

Top module: `frac_scaler`

## Requirements
- R1: `frame_o` is high in exactly the fifth cycle after a cycle with `sof_i` high. Result bit i of every output stream is presented i cycles after `frame_o`, least significant bit first.
- R2: `y38_o` carries floor(3x/8) as a W-bit word. An input of 16 gives 6, and an all-zero operand gives 0 on every stream.
- R3: `y78_o` carries floor(7x/8). An input of 16 gives 14.
- R4: `y1116_o` carries floor(11x/16). An input of 16 gives 11.
- R5: `y716_o` carries floor(7x/16). An input of 16 gives 7.
- R6: Negative operands are scaled with rounding toward negative infinity, and the top result bit of every stream equals the operand's sign bit. An input of -1 gives -1 on all streams. An input of -16 gives -6, -14, -11 and -7.
- R7: `din_i` is ignored from the cycle after operand bit W-1 until the next `sof_i`. Any values driven there leave all four results unchanged.
- R8: Strobes may follow each other at a spacing of W+4 cycles or more. Consecutive words at the minimum spacing give independent, correct results.
- R9: After reset, and until the first strobe, `frame_o` and all four result streams are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | High with the least significant operand bit |
| din_i | input | 1 | Operand bit stream, LSB first, W bits per word |
| frame_o | output | 1 | High with the least significant result bit |
| y38_o | output | 1 | x·3/8 stream |
| y78_o | output | 1 | x·7/8 stream |
| y1116_o | output | 1 | x·11/16 stream |
| y716_o | output | 1 | x·7/16 stream |

## Verification
The properties assume that `sof_i` stays low during reset and that consecutive strobes are at least W+4 cycles apart. The spacing matters because the sign extension and the final carries of one word must finish before the next word's carry preset. One property checks this spacing rule directly. The driver task always leaves at least four cycles after the last operand bit before it raises the next strobe. It fills those cycles with random bits, so the rule that they are ignored is tested on every word. The zero-output and sign-bit properties follow the output frame by counting cycles from the input strobe, so they depend on the same spacing assumption.

// File: rtl/fracscale_pkg.sv
package fracscale_pkg;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_BITS   = 2'd1,
        FS_EXTEND = 2'd2
    } fs_state_e;

    // Number of result streams and the bits each one drops from its multiple
    localparam int N_OUT   = 4;
    localparam int MAX_SH  = 4;
    localparam int OUT_LAT = MAX_SH + 1;

    // 0: 3/8   1: 7/8   2: 11/16   3: 7/16
    function automatic int out_shift(input int k);
        case (k)
            0, 1:    return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/frac_frame_fsm.sv
module frac_frame_fsm
    import fracscale_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sof,
    input  logic                       din,
    output logic                       xe,
    output logic                       first,
    output logic [$clog2(W+1)-1:0]     pos
);
    localparam int IW = $clog2(W + 1);

    fs_state_e       state_q, state_d;
    logic [IW-1:0]   pos_q, pos_d;
    logic            sign_q;
    logic            cap;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            pos_q   <= IW'(W);
            sign_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            if (cap) sign_q <= din;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        cap     = 1'b0;
        if (sof) begin
            state_d = FS_BITS;
            pos_d   = IW'(1);
        end else begin
            unique case (state_q)
                FS_IDLE:   ;
                FS_BITS: begin
                    if (pos_q == IW'(W - 1)) begin
                        cap     = 1'b1;
                        state_d = FS_EXTEND;
                        pos_d   = IW'(W);
                    end else begin
                        pos_d = pos_q + IW'(1);
                    end
                end
                FS_EXTEND: ;
                default:   state_d = FS_IDLE;
            endcase
        end
    end

    // outputs: extended operand bit, frame start, bit index
    always_comb begin
        first = sof;
        pos   = sof ? '0 : pos_q;
        xe    = 1'b0;
        if (sof) begin
            xe = din;
        end else begin
            unique case (state_q)
                FS_IDLE:   xe = 1'b0;
                FS_BITS:   xe = din;
                FS_EXTEND: xe = sign_q;
                default:   xe = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/frac_serial_add.sv
module frac_serial_add #(
    parameter bit SUB = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic first,
    input  logic a,
    input  logic b,
    output logic s
);
    localparam logic CINIT = SUB;

    logic c_q, cin, b_eff, cout;

    always_comb begin
        b_eff = b ^ SUB;
        cin   = first ? CINIT : c_q;
        s     = a ^ b_eff ^ cin;
        cout  = (a & b_eff) | (a & cin) | (b_eff & cin);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= CINIT;
        else        c_q <= cout;
    end

endmodule

// File: rtl/frac_delay_line.sv
module frac_delay_line #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (DEPTH == 1) begin : g_one
            logic r;
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [DEPTH-1:0] r;
            always_ff @(posedge clk) begin
                if (!rst_n) r <= '0;
                else        r <= {r[DEPTH-2:0], d};
            end
            assign q = r[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/frac_scaler.sv
module frac_scaler
    import fracscale_pkg::*;
#(
    parameter int W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic din_i,
    output logic frame_o,
    output logic y38_o,
    output logic y78_o,
    output logic y1116_o,
    output logic y716_o
);
    localparam int IW = $clog2(W + 1);

    logic          xe, first;
    logic [IW-1:0] pos;
    logic          d1, d3;
    logic          t1, t3;
    logic          z3, z7, z11;
    logic [N_OUT-1:0] z_all, y_all;

    frac_frame_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sof(sof_i), .din(din_i),
        .xe(xe), .first(first), .pos(pos)
    );

    // x shifted up by one and by three bit periods
    frac_delay_line #(.DEPTH(1)) u_dly1 (.clk(clk), .rst_n(rst_n), .d(xe), .q(d1));
    frac_delay_line #(.DEPTH(2)) u_dly3 (.clk(clk), .rst_n(rst_n), .d(d1), .q(d3));

    // shifted terms are zero below their shift within a word
    assign t1 = (pos >= IW'(1)) & d1;
    assign t3 = (pos >= IW'(3)) & d3;

    // 3x = x + 2x
    frac_serial_add #(.SUB(1'b0)) u_add3 (
        .clk(clk), .rst_n(rst_n), .first(first), .a(xe), .b(t1), .s(z3)
    );
    // 7x = 8x - x
    frac_serial_add #(.SUB(1'b1)) u_sub7 (
        .clk(clk), .rst_n(rst_n), .first(first), .a(t3), .b(xe), .s(z7)
    );
    // 11x = 8x + 3x
    frac_serial_add #(.SUB(1'b0)) u_add11 (
        .clk(clk), .rst_n(rst_n), .first(first), .a(t3), .b(z3), .s(z11)
    );

    assign z_all = {z7, z11, z7, z3};

    // equalise every stream to OUT_LAT
    for (genvar g = 0; g < N_OUT; g++) begin : g_align
        localparam int DLY = OUT_LAT - out_shift(g);
        frac_delay_line #(.DEPTH(DLY)) u_eq (
            .clk(clk), .rst_n(rst_n), .d(z_all[g]), .q(y_all[g])
        );
    end

    frac_delay_line #(.DEPTH(OUT_LAT)) u_frame (
        .clk(clk), .rst_n(rst_n), .d(sof_i), .q(frame_o)
    );

    assign y38_o   = y_all[0];
    assign y78_o   = y_all[1];
    assign y1116_o = y_all[2];
    assign y716_o  = y_all[3];

endmodule

// File: rtl/frac_scaler_chk.sv
module frac_scaler_chk
    import fracscale_pkg::*;
#(
    parameter int W = 12
) (
    input logic clk,
    input logic rst_n,
    input logic sof_i,
    input logic din_i,
    input logic frame_o,
    input logic y38_o,
    input logic y78_o,
    input logic y1116_o,
    input logic y716_o
);
    localparam int SPACE = W + MAX_SH;
    localparam int CW    = $clog2(SPACE + 1);

    logic [CW-1:0] in_q, in_cur, out_q, out_cur;
    logic          sgn_q, pz_q, pz_cur;

    always_comb begin
        in_cur  = sof_i   ? '0 : in_q;
        out_cur = frame_o ? '0 : out_q;
        if (sof_i)                pz_cur = ~din_i;
        else if (in_cur < CW'(W)) pz_cur = pz_q & ~din_i;
        else                      pz_cur = pz_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q  <= CW'(SPACE);
            out_q <= CW'(W);
            sgn_q <= 1'b0;
            pz_q  <= 1'b0;
        end else begin
            in_q  <= (in_cur == CW'(SPACE)) ? in_cur : in_cur + CW'(1);
            out_q <= (out_cur == CW'(W))    ? out_cur : out_cur + CW'(1);
            if (in_cur == CW'(W - 1)) sgn_q <= din_i;
            pz_q  <= pz_cur;
        end
    end

    assert_frame_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o == $past(sof_i, OUT_LAT));

    assert_zero_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cur < CW'(W)) && $past(pz_cur) |->
            !(y38_o | y78_o | y1116_o | y716_o));

    assert_top_bit_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cur == CW'(W - 1)) |->
            (y38_o == sgn_q) && (y78_o == sgn_q) && (y1116_o == sgn_q) && (y716_o == sgn_q));

    assert_frame_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |-> in_q == CW'(SPACE));

endmodule

bind frac_scaler frac_scaler_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .din_i(din_i),
    .frame_o(frame_o), .y38_o(y38_o), .y78_o(y78_o),
    .y1116_o(y1116_o), .y716_o(y716_o)
);

// File: tb/frac_scaler_tb.sv
`timescale 1ns/1ps
module frac_scaler_tb;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof_i = 1'b0;
    logic din_i = 1'b0;
    logic frame_o, y38_o, y78_o, y1116_o, y716_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    typedef struct {
        int    x;
        int    cyc;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_scaler #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .din_i(din_i),
        .frame_o(frame_o), .y38_o(y38_o), .y78_o(y78_o),
        .y1116_o(y1116_o), .y716_o(y716_o)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    // driver: one word plus at least four gap cycles of random filler
    task automatic send_word(input int x, input int idle, input string tag);
        item_t it;
        logic [W-1:0] v;
        v = W'(x);
        @(negedge clk);
        sof_i = 1'b1;
        din_i = v[0];
        it.x = x; it.cyc = cyc; it.tag = tag;
        exp_q.push_back(it);
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            sof_i = 1'b0;
            din_i = v[i];
        end
        for (int i = 0; i < 4 + idle; i++) begin
            @(negedge clk);
            sof_i = 1'b0;
            din_i = 1'($urandom);
        end
    endtask

    // monitor: collect each output frame and compare with the scoreboard
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && frame_o) begin
                int st;
                logic [W-1:0] v38, v78, v1116, v716;
                st = cyc;
                for (int i = 0; i < W; i++) begin
                    if (i > 0) begin @(posedge clk); #1; end
                    v38[i] = y38_o; v78[i] = y78_o; v1116[i] = y1116_o; v716[i] = y716_o;
                end
                if (exp_q.size() == 0) begin
                    check("R1 unexpected frame", 1, 0);
                end else begin
                    item_t it;
                    int g38, g78, g1116, g716;
                    it = exp_q.pop_front();
                    g38 = $signed(v38); g78 = $signed(v78);
                    g1116 = $signed(v1116); g716 = $signed(v716);
                    check($sformatf("R1 latency x=%0d", it.x), st - it.cyc, 5);
                    check($sformatf("R2 3/8 x=%0d (%s)", it.x, it.tag), g38, (3 * it.x) >>> 3);
                    check($sformatf("R3 7/8 x=%0d (%s)", it.x, it.tag), g78, (7 * it.x) >>> 3);
                    check($sformatf("R4 11/16 x=%0d (%s)", it.x, it.tag), g1116, (11 * it.x) >>> 4);
                    check($sformatf("R5 7/16 x=%0d (%s)", it.x, it.tag), g716, (7 * it.x) >>> 4);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 1, 0);
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R9: idle after reset gives zero outputs
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            check("R9 idle frame_o", int'(frame_o), 0);
            check("R9 idle streams", int'({y38_o, y78_o, y1116_o, y716_o}), 0);
        end

        send_word(16, 0, "R2 reference");
        send_word(0, 0, "R2 zero, R7 filler");
        send_word(1, 0, "R8 back-to-back");
        send_word(7, 0, "R8 back-to-back");
        send_word(-1, 0, "R6 minus one");
        send_word(-16, 3, "R6 minus sixteen");
        send_word(-2048, 0, "R6 most negative");
        send_word(2047, 0, "R8 most positive");
        send_word(-7, 2, "R6 odd negative");
        for (int k = 0; k < 8; k++)
            send_word(int'($urandom_range(4095)) - 2048, k % 3, "R7 random filler");

        repeat (W + 12) @(posedge clk);
        #1;
        check("R1 frames outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule